// File: doc/BRIEF.md
# Interrupt Gating and Status Stack Unit

This unit sits beside the sequencer of a small processor core and decides which interrupt the core takes next. Requests from peripherals are latched into a pending vector. Software can set or drop any pending bit through a write port that holds no readable state. A per-source enable mask and a single global enable control which pending bits are eligible. The global enable has its own set and clear strobes.

When the core signals that it can take an interrupt, the unit picks the lowest-numbered eligible source. It reports that source on a one-cycle acknowledge with its index, clears the source's pending bit, and pushes the core's status word onto a twelve-level stack. The same stack serves loop and subroutine nesting through explicit push and pop strobes. A push into a full stack is dropped and raises a sticky overflow flag. A pop from an empty stack raises a sticky underflow flag. DMA and autobuffer request lines pass through a register stage and are never gated by the global enable.

Top module: `irq_gate_unit`

## Requirements
- R1: Reset leaves the pending vector empty, every mask bit 0 (source not eligible), the global enable on, the stack empty with `top_o` = 0, both flags low and `ack_o` low.
- R2: A 1 on `req_i[i]` in any cycle sets pending bit i. The bit stays set until the source is acknowledged or cleared by software.
- R3: When `force_we_i` is 1, each 1 in `force_bits_i` sets the matching pending bit and each 1 in `clear_bits_i` clears it. If a bit is in both vectors, the clear takes effect.
- R4: Mask bit i = 1 makes source i eligible. A pending source whose mask bit is 0 is never acknowledged but stays pending, so it can be acknowledged once its mask bit is set.
- R5: `gen_clr_i` turns the global enable off and `gen_set_i` turns it on, and the clear wins when both are high. While the enable is off, no source is acknowledged whatever the mask holds. `gen_en_o` shows the enable state one cycle after the strobe.
- R6: If `accept_i` is 1, the enable is on, at least one source is pending and unmasked, and neither `push_i` nor `pop_i` is high, then in the next cycle `ack_o` = 1, `ack_vec_o` holds the lowest-numbered eligible index, and `top_o` = the `status_i` value from the accept cycle. The acknowledged pending bit is cleared.
- R7: The stack holds 12 entries in LIFO order. `push_i` stores `push_data_i`, `pop_i` removes the top, `depth_o` counts the entries, and `push_i` together with `pop_i` changes nothing.
- R8: A push (explicit or by acknowledge) when 12 entries are held is discarded and leaves the contents unchanged. It sets `ovf_o`, which stays set until reset.
- R9: A pop with the stack empty sets `unf_o`, which stays set until reset, and leaves `depth_o` at 0.
- R10: `dma_req_o` equals `dma_req_i` from the previous cycle, whether the global enable is on or off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_SRC | Interrupt request lines, latched as pending |
| mask_we_i | input | 1 | Write strobe for the mask register |
| mask_i | input | N_SRC | New mask value (1 = eligible) |
| force_we_i | input | 1 | Write strobe for the force/clear port |
| force_bits_i | input | N_SRC | Pending bits to set |
| clear_bits_i | input | N_SRC | Pending bits to clear (wins over set) |
| gen_set_i | input | 1 | Global enable on |
| gen_clr_i | input | 1 | Global enable off |
| accept_i | input | 1 | Core can take an interrupt this cycle |
| status_i | input | SW | Status word pushed on acknowledge |
| ack_o | output | 1 | Interrupt acknowledged (one cycle per take) |
| ack_vec_o | output | IW | Index of the acknowledged source |
| gen_en_o | output | 1 | Global enable state |
| push_i | input | 1 | Explicit stack push |
| pop_i | input | 1 | Stack pop |
| push_data_i | input | SW | Word for an explicit push |
| top_o | output | SW | Top stack entry, 0 when empty |
| depth_o | output | DW | Number of entries held |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |
| dma_req_i | input | DMA_W | DMA and autobuffer requests in |
| dma_req_o | output | DMA_W | Registered copy, never gated |

## Verification
Every result of this unit is registered once. A force, clear, request, mask write or enable strobe sampled at one rising edge becomes observable through the acknowledge path at the following accept edge. An acknowledge, its index and the pushed status word appear one cycle after the accept edge. Stack depth, top and flags change one cycle after a push or pop, and the DMA copy lags its input by one cycle. The bench changes inputs at the falling edge and reads outputs at the next falling edge, so each sample falls exactly one rising edge after the stimulus. The priority sweeps run over all 255 pending patterns and all 256 mask values, and the expected index is computed as the lowest set bit.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    typedef enum logic [1:0] {
        STK_NONE = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N_SRC = 8,
    parameter int IW    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] cand_i,
    output logic             found_o,
    output logic [IW-1:0]    idx_o
);

    // lowest index wins: scan from the top so the last hit is the smallest
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_status_stack.sv
module irq_status_stack
    import irq_gate_pkg::*;
#(
    parameter int DEPTH = 12,
    parameter int SW    = 16,
    parameter int DW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  stk_op_e       op_i,
    input  logic [SW-1:0] wdata_i,
    output logic [SW-1:0] top_o,
    output logic [DW-1:0] depth_o,
    output logic          ovf_o,
    output logic          unf_o
);

    localparam logic [DW-1:0] FULL = DW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][SW-1:0] mem;
        logic [DW-1:0]            cnt;
        logic                     ovf;
        logic                     unf;
    } stk_t;

    stk_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (op_i)
            STK_PUSH: begin
                if (s_q.cnt == FULL) begin
                    s_d.ovf = 1'b1;
                end else begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if (s_q.cnt == DW'(i)) s_d.mem[i] = wdata_i;
                    end
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            STK_POP: begin
                if (s_q.cnt == '0) s_d.unf = 1'b1;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        top_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (s_q.cnt == DW'(i + 1)) top_o = s_q.mem[i];
        end
    end

    assign depth_o = s_q.cnt;
    assign ovf_o   = s_q.ovf;
    assign unf_o   = s_q.unf;

endmodule

// File: rtl/irq_gate_unit.sv
module irq_gate_unit
    import irq_gate_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int DEPTH = 12,
    parameter int SW    = 16,
    parameter int DMA_W = 4,
    parameter int IW    = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    parameter int DW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    input  logic             mask_we_i,
    input  logic [N_SRC-1:0] mask_i,
    input  logic             force_we_i,
    input  logic [N_SRC-1:0] force_bits_i,
    input  logic [N_SRC-1:0] clear_bits_i,
    input  logic             gen_set_i,
    input  logic             gen_clr_i,
    input  logic             accept_i,
    input  logic [SW-1:0]    status_i,
    output logic             ack_o,
    output logic [IW-1:0]    ack_vec_o,
    output logic             gen_en_o,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [SW-1:0]    push_data_i,
    output logic [SW-1:0]    top_o,
    output logic [DW-1:0]    depth_o,
    output logic             ovf_o,
    output logic             unf_o,
    input  logic [DMA_W-1:0] dma_req_i,
    output logic [DMA_W-1:0] dma_req_o
);

    typedef struct packed {
        logic [N_SRC-1:0] pend;
        logic [N_SRC-1:0] mask;
        logic             gen;
        logic             ack;
        logic [IW-1:0]    ack_vec;
        logic [DMA_W-1:0] dma;
    } gate_t;

    gate_t s_d, s_q;

    logic [N_SRC-1:0] cand;
    logic             found;
    logic [IW-1:0]    win_idx;
    logic             take;
    logic [N_SRC-1:0] take_oh;
    logic [N_SRC-1:0] set_v, clr_v;
    stk_op_e          stk_op;
    logic [SW-1:0]    stk_wdata;

    assign cand = s_q.pend & s_q.mask;

    irq_prio_enc #(.N_SRC(N_SRC), .IW(IW)) u_prio (
        .cand_i  (cand),
        .found_o (found),
        .idx_o   (win_idx)
    );

    // a stack strobe from the sequencer owns the stack this cycle
    assign take  = accept_i & s_q.gen & found & ~push_i & ~pop_i;
    assign set_v = force_we_i ? force_bits_i : '0;
    assign clr_v = force_we_i ? clear_bits_i : '0;

    for (genvar g = 0; g < N_SRC; g++) begin : g_oh
        assign take_oh[g] = take && (win_idx == IW'(g));
    end

    always_comb begin
        s_d      = s_q;
        s_d.pend = ((s_q.pend & ~take_oh) | req_i | set_v) & ~clr_v;
        if (mask_we_i) s_d.mask = mask_i;
        if (gen_clr_i)      s_d.gen = 1'b0;
        else if (gen_set_i) s_d.gen = 1'b1;
        s_d.ack     = take;
        s_d.ack_vec = take ? win_idx : '0;
        s_d.dma     = dma_req_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.gen <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        stk_op    = STK_NONE;
        stk_wdata = push_data_i;
        if (take) begin
            stk_op    = STK_PUSH;
            stk_wdata = status_i;
        end else if (push_i && !pop_i) begin
            stk_op = STK_PUSH;
        end else if (pop_i && !push_i) begin
            stk_op = STK_POP;
        end
    end

    irq_status_stack #(.DEPTH(DEPTH), .SW(SW), .DW(DW)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (stk_op),
        .wdata_i (stk_wdata),
        .top_o   (top_o),
        .depth_o (depth_o),
        .ovf_o   (ovf_o),
        .unf_o   (unf_o)
    );

    assign ack_o     = s_q.ack;
    assign ack_vec_o = s_q.ack_vec;
    assign gen_en_o  = s_q.gen;
    assign dma_req_o = s_q.dma;

endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
    parameter int DEPTH = 12,
    parameter int DMA_W = 4,
    parameter int DW    = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gen_set_i,
    input logic             gen_clr_i,
    input logic             accept_i,
    input logic             push_i,
    input logic             pop_i,
    input logic             ack_o,
    input logic             gen_en_o,
    input logic [DW-1:0]    depth_o,
    input logic             ovf_o,
    input logic             unf_o,
    input logic [DMA_W-1:0] dma_req_i,
    input logic [DMA_W-1:0] dma_req_o
);

    logic armed_q;
    always_ff @(posedge clk) armed_q <= rst_n;

    a_r5_off_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !gen_en_o) |=> !ack_o);

    a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        gen_clr_i |=> !gen_en_o);

    a_r5_set_on: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_set_i && !gen_clr_i) |=> gen_en_o);

    a_r6_ack_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ack_o) |-> $past(accept_i && !push_i && !pop_i));

    a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        depth_o <= DW'(DEPTH));

    a_r7_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && depth_o < DW'(DEPTH)) |=> depth_o == $past(depth_o) + 1'b1);

    a_r8_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && depth_o == DW'(DEPTH)) |=> (ovf_o && depth_o == DW'(DEPTH)));

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    a_r9_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && depth_o == '0) |=> (unf_o && depth_o == '0));

    a_r10_dma_follows: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> dma_req_o == $past(dma_req_i));

endmodule

bind irq_gate_unit irq_gate_chk #(.DEPTH(DEPTH), .DMA_W(DMA_W), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen_set_i (gen_set_i),
    .gen_clr_i (gen_clr_i),
    .accept_i  (accept_i),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .ack_o     (ack_o),
    .gen_en_o  (gen_en_o),
    .depth_o   (depth_o),
    .ovf_o     (ovf_o),
    .unf_o     (unf_o),
    .dma_req_i (dma_req_i),
    .dma_req_o (dma_req_o)
);

// File: tb/tb_irq_gate_unit.sv
`timescale 1ns/1ps
module tb_irq_gate_unit;

    localparam int N  = 8;
    localparam int D  = 12;
    localparam int SW = 16;
    localparam int DM = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req_i = '0, mask_i = '0, force_bits_i = '0, clear_bits_i = '0;
    logic          mask_we_i = 0, force_we_i = 0, gen_set_i = 0, gen_clr_i = 0, accept_i = 0;
    logic [SW-1:0] status_i = '0, push_data_i = '0;
    logic          push_i = 0, pop_i = 0;
    logic [DM-1:0] dma_req_i = '0;
    logic          ack_o, gen_en_o, ovf_o, unf_o;
    logic [2:0]    ack_vec_o;
    logic [SW-1:0] top_o;
    logic [3:0]    depth_o;
    logic [DM-1:0] dma_req_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_gate_unit dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_we_i(mask_we_i), .mask_i(mask_i),
        .force_we_i(force_we_i), .force_bits_i(force_bits_i), .clear_bits_i(clear_bits_i),
        .gen_set_i(gen_set_i), .gen_clr_i(gen_clr_i), .accept_i(accept_i), .status_i(status_i),
        .ack_o(ack_o), .ack_vec_o(ack_vec_o), .gen_en_o(gen_en_o), .push_i(push_i), .pop_i(pop_i),
        .push_data_i(push_data_i), .top_o(top_o), .depth_o(depth_o), .ovf_o(ovf_o), .unf_o(unf_o),
        .dma_req_i(dma_req_i), .dma_req_o(dma_req_o)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic do_force(input logic [N-1:0] f, input logic [N-1:0] c);
        force_we_i = 1; force_bits_i = f; clear_bits_i = c;
        tick();
        force_we_i = 0; force_bits_i = '0; clear_bits_i = '0;
    endtask

    task automatic do_accept(input logic [SW-1:0] st);
        accept_i = 1; status_i = st;
        tick();
        accept_i = 0;
    endtask

    task automatic set_mask(input logic [N-1:0] m);
        mask_we_i = 1; mask_i = m;
        tick();
        mask_we_i = 0;
    endtask

    // drop all pending bits and, when an entry was pushed, pop it
    task automatic flush(input bit had_ack);
        force_we_i = 1; clear_bits_i = '1; pop_i = had_ack;
        tick();
        force_we_i = 0; clear_bits_i = '0; pop_i = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1 ack", ack_o, 0);
        chk("R1 gen_en", gen_en_o, 1);
        chk("R1 depth", depth_o, 0);
        chk("R1 top", top_o, 0);
        chk("R1 ovf", ovf_o, 0);
        chk("R1 unf", unf_o, 0);
        // R1 mask zero: forced source not taken before any mask write
        do_force(8'h01, 8'h00);
        do_accept(16'h1);
        chk("R1 mask cleared", ack_o, 0);
        flush(0);
        set_mask('1);
        do_accept(16'h1);
        chk("R1 pending empty", ack_o, 0);

        // R6 sweep over every pending pattern
        for (int p = 1; p < 256; p++) begin
            do_force(N'(p), '0);
            do_accept(SW'(p));
            chk("R6 ack", ack_o, 1);
            chk("R6 vector", ack_vec_o, lowest(N'(p)));
            chk("R6 status pushed", top_o, p);
            flush(1);
        end
        chk("R7 depth after sweep", depth_o, 0);

        // R4 sweep over every mask value with all sources pending
        for (int m = 0; m < 256; m++) begin
            set_mask(N'(m));
            do_force('1, '0);
            do_accept(16'h55);
            chk("R4 ack", ack_o, (m != 0) ? 1 : 0);
            if (m != 0) chk("R4 vector", ack_vec_o, lowest(N'(m)));
            flush(m != 0);
        end

        // R4 masked source stays pending
        set_mask(8'h00);
        do_force(8'h04, '0);
        do_accept(16'h2);
        chk("R4 masked no ack", ack_o, 0);
        set_mask(8'h04);
        do_accept(16'h2);
        chk("R4 unmasked later ack", ack_o, 1);
        chk("R4 unmasked later vector", ack_vec_o, 2);
        flush(1);
        set_mask('1);

        // R3 clear wins on the same bit
        do_force(8'h01, 8'h01);
        do_accept(16'h3);
        chk("R3 clear wins", ack_o, 0);
        do_force(8'h03, 8'h01);
        do_accept(16'h3);
        chk("R3 partial clear vector", ack_vec_o, 1);
        flush(1);

        // R2 request pulse latched
        req_i = 8'h20; tick(); req_i = '0;
        repeat (3) tick();
        do_accept(16'h4);
        chk("R2 latched ack", ack_o, 1);
        chk("R2 latched vector", ack_vec_o, 5);
        do_accept(16'h4);
        chk("R2 cleared by ack", ack_o, 0);
        flush(1);

        // R5 global enable
        gen_clr_i = 1; tick(); gen_clr_i = 0;
        chk("R5 disabled", gen_en_o, 0);
        do_force(8'h01, '0);
        do_accept(16'h5);
        chk("R5 no ack when off", ack_o, 0);
        gen_set_i = 1; tick(); gen_set_i = 0;
        chk("R5 enabled", gen_en_o, 1);
        do_accept(16'h5);
        chk("R5 ack after enable", ack_o, 1);
        flush(1);
        gen_set_i = 1; gen_clr_i = 1; tick(); gen_set_i = 0; gen_clr_i = 0;
        chk("R5 clear wins", gen_en_o, 0);

        // R10 DMA passes while disabled
        dma_req_i = 4'b1010; tick();
        chk("R10 dma a", dma_req_o, 4'b1010);
        dma_req_i = 4'b0101; tick();
        chk("R10 dma b", dma_req_o, 4'b0101);
        dma_req_i = '0;
        gen_set_i = 1; tick(); gen_set_i = 0;

        // R6 accept blocked by a stack strobe
        do_force(8'h02, '0);
        accept_i = 1; push_i = 1; push_data_i = 16'h77; tick();
        accept_i = 0; push_i = 0;
        chk("R6 blocked by push", ack_o, 0);
        chk("R7 push value", top_o, 16'h77);
        flush(1);

        // R7 fill, R8 overflow, LIFO drain, R9 underflow
        for (int i = 0; i < D; i++) begin
            push_i = 1; push_data_i = SW'(16'hA000 + i); tick();
        end
        push_i = 0;
        chk("R7 full depth", depth_o, D);
        chk("R7 full top", top_o, 16'hA00B);
        push_i = 1; pop_i = 1; tick(); push_i = 0; pop_i = 0;
        chk("R7 push+pop no-op", depth_o, D);
        chk("R8 no ovf yet", ovf_o, 0);
        push_i = 1; push_data_i = 16'hBEEF; tick(); push_i = 0;
        chk("R8 ovf set", ovf_o, 1);
        chk("R8 depth held", depth_o, D);
        chk("R8 top kept", top_o, 16'hA00B);
        for (int i = D - 1; i >= 0; i--) begin
            chk("R7 lifo", top_o, 16'hA000 + i);
            pop_i = 1; tick(); pop_i = 0;
        end
        chk("R7 empty", depth_o, 0);
        chk("R8 ovf sticky", ovf_o, 1);
        chk("R9 no unf yet", unf_o, 0);
        pop_i = 1; tick(); pop_i = 0;
        chk("R9 unf set", unf_o, 1);
        chk("R9 depth zero", depth_o, 0);
        tick();
        chk("R9 unf sticky", unf_o, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule